// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block holds one word of pending message bits for each core in a multi-core cluster and lets cores signal each other. In any cycle, each of several sender ports can present a valid strobe, a bitmask of target cores and a 3-bit message type. Every addressed core gets the bit whose position equals the type code set in its pending word, and its interrupt line goes high. Bits are sticky: several message kinds can wait side by side until the target drains them.

A target core drains its word with a swap-to-zero port. While the core's swap request is high, the current pending word appears on that core's return field in the same cycle, and the word is cleared at the next clock edge. If a message bit lands on that core in the same cycle as the clear, the bit does not appear in the returned value. It survives in the word left after the clear. The core's handler therefore repeats the swap until the returned word is zero. Core count and sender count are parameters, and the core count may be anything from 2 to 32.

Top module: `ipi_mbox`

## Requirements
- R1: Type codes and bit positions: 1 = reschedule (bit 1), 2 = call a function on a group of cores (bit 2), 3 = call a function on one core (bit 3), 4 = stop the core (bit 4). Each pending word is 5 bits wide, and bit n is set by type n.
- R2: A valid send sets its bit in every core whose bit in that sender's mask is 1. It leaves every other core's word unchanged.
- R3: When several valid senders address the same core in the same cycle, that core's word takes the OR of all their bits.
- R4: Pending bits stay set across cycles, and further sends accumulate on top of them, until that core swaps.
- R5: While `swapReq[c]` is high, `swapData` field c (bits c*5 to c*5+4) carries the pending word from before the edge. After that edge the word holds only bits set in the swap cycle. While `swapReq[c]` is low, the field reads zero.
- R6: A bit set in the same cycle as a swap of the same core is absent from that swap's returned value and present in the word after the edge.
- R7: `irq[c]` is high exactly when core c's pending word is nonzero. It rises on the clock edge that captures a send and falls on the edge of a swap that has no new bits.
- R8: Type 0 (no-op) and the unused codes 5 to 7 set no bit and raise no interrupt.
- R9: After reset every pending word is zero, every `irq` is low and every `swapData` field reads zero.
- R10: A sender whose valid is low has no effect, whatever its mask and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sendValid | input | NUM_SENDERS | Per-sender send strobe |
| sendMask | input | NUM_SENDERS*NUM_CORES | Target core mask, sender s at bits s*NUM_CORES upward |
| sendType | input | NUM_SENDERS*3 | Message type code, sender s at bits s*3 upward |
| swapReq | input | NUM_CORES | Per-core swap-to-zero request |
| swapData | output | NUM_CORES*5 | Per-core returned pending word, valid while swapReq is high |
| irq | output | NUM_CORES | Per-core interrupt, high while the pending word is nonzero |

## Verification
The bench targets a send and a swap that hit the same core in the same cycle. A design that gives the clear priority would lose the new bit, and one that forwards the new bit would return it early and then clear it. It drives two senders at one core with different types, where a design that keeps only one sender's bits would drop a message. It also sends no-op and out-of-range codes, which must leave the interrupt low. A multi-target stop to every core but one checks that the excluded core stays untouched.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int TYPE_W = 3;
  localparam int PEND_W = 5;

  typedef enum logic [TYPE_W-1:0] {
    MSG_NOP      = 3'd0,
    MSG_RESCHED  = 3'd1,
    MSG_CALL_SET = 3'd2,
    MSG_CALL_ONE = 3'd3,
    MSG_STOP     = 3'd4
  } msgType_e;

  typedef struct packed {
    logic              clr;
    logic [PEND_W-1:0] setBits;
  } coreStrobe_t;

  function automatic logic [PEND_W-1:0] codeToBit(input logic [TYPE_W-1:0] code);
    logic [PEND_W-1:0] bitVec;
    bitVec = '0;
    case (code)
      MSG_RESCHED:  bitVec[1] = 1'b1;
      MSG_CALL_SET: bitVec[2] = 1'b1;
      MSG_CALL_ONE: bitVec[3] = 1'b1;
      MSG_STOP:     bitVec[4] = 1'b1;
      default:      bitVec = '0;
    endcase
    return bitVec;
  endfunction
endpackage

// File: rtl/ipi_mbox_ctrl.sv
module ipi_mbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_SENDERS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SENDERS-1:0]            sendValid,
  input  logic [NUM_SENDERS*NUM_CORES-1:0]  sendMask,
  input  logic [NUM_SENDERS*TYPE_W-1:0]     sendType,
  input  logic [NUM_CORES-1:0]              swapReq,
  output coreStrobe_t [NUM_CORES-1:0]       strobes
);
  logic [NUM_CORES-1:0] coreHit;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      strobes[c].setBits = '0;
      strobes[c].clr     = swapReq[c];
      for (int s = 0; s < NUM_SENDERS; s++) begin
        if (sendValid[s] && sendMask[s*NUM_CORES + c]) begin
          strobes[c].setBits = strobes[c].setBits | codeToBit(sendType[s*TYPE_W +: TYPE_W]);
        end
      end
    end
  end

  always_comb begin
    coreHit = '0;
    for (int s = 0; s < NUM_SENDERS; s++) begin
      coreHit = coreHit | (sendMask[s*NUM_CORES +: NUM_CORES] & {NUM_CORES{sendValid[s]}});
    end
  end

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
      AST_UNADDRESSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !coreHit[c] |-> strobes[c].setBits == '0); // R2
      AST_NOOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        strobes[c].setBits[0] == 1'b0); // R8
    end
  endgenerate
endmodule

// File: rtl/ipi_mbox_dp.sv
module ipi_mbox_dp
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  coreStrobe_t [NUM_CORES-1:0]   strobes,
  output logic [NUM_CORES*PEND_W-1:0]   swapData,
  output logic [NUM_CORES-1:0]          irq
);
  logic [PEND_W-1:0] pendWord [NUM_CORES];

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      always_ff @(posedge clk) begin
        if (!rst_n) pendWord[c] <= '0;
        else        pendWord[c] <= (strobes[c].clr ? '0 : pendWord[c]) | strobes[c].setBits;
      end

      assign irq[c] = |pendWord[c];
      assign swapData[c*PEND_W +: PEND_W] = strobes[c].clr ? pendWord[c] : '0;

      AST_SWAP_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        strobes[c].clr |=> pendWord[c] == $past(strobes[c].setBits)); // R6
      AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobes[c].clr |=> (pendWord[c] & $past(pendWord[c])) == $past(pendWord[c])); // R4
      AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes[c].setBits) |=> irq[c]); // R7
      AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobes[c].clr && strobes[c].setBits == '0) |=> $stable(pendWord[c])); // R4
    end
  endgenerate
endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_SENDERS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SENDERS-1:0]            sendValid,
  input  logic [NUM_SENDERS*NUM_CORES-1:0]  sendMask,
  input  logic [NUM_SENDERS*3-1:0]          sendType,
  input  logic [NUM_CORES-1:0]              swapReq,
  output logic [NUM_CORES*5-1:0]            swapData,
  output logic [NUM_CORES-1:0]              irq
);
  coreStrobe_t [NUM_CORES-1:0] strobes;

  ipi_mbox_ctrl #(.NUM_CORES(NUM_CORES), .NUM_SENDERS(NUM_SENDERS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sendValid(sendValid), .sendMask(sendMask),
    .sendType(sendType), .swapReq(swapReq), .strobes(strobes)
  );

  ipi_mbox_dp #(.NUM_CORES(NUM_CORES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .swapData(swapData), .irq(irq)
  );
endmodule

// File: tb/ipi_mbox_tb_top.sv
module ipi_mbox_tb_top;
  localparam int NC = 4;
  localparam int NS = 2;
  localparam int PW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     sendValid = '0;
  logic [NS*NC-1:0]  sendMask = '0;
  logic [NS*3-1:0]   sendType = '0;
  logic [NC-1:0]     swapReq = '0;
  logic [NC*PW-1:0]  swapData;
  logic [NC-1:0]     irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [PW-1:0] model [NC];

  always #4 clk = ~clk;

  ipi_mbox #(.NUM_CORES(NC), .NUM_SENDERS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sendValid(sendValid), .sendMask(sendMask),
    .sendType(sendType), .swapReq(swapReq), .swapData(swapData), .irq(irq)
  );

  function automatic logic [PW-1:0] expBit(input logic [2:0] code);
    logic [PW-1:0] r = '0;
    if (code >= 3'd1 && code <= 3'd4) r[code] = 1'b1;
    return r;
  endfunction

  function automatic logic [PW-1:0] expSet(input logic [NS-1:0] v, input logic [NS*NC-1:0] m,
                                          input logic [NS*3-1:0] t, input int c);
    logic [PW-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      if (v[s] && m[s*NC + c]) r = r | expBit(t[s*3 +: 3]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [NS-1:0] v, input logic [NS*NC-1:0] m,
                      input logic [NS*3-1:0] t, input logic [NC-1:0] sw);
    @(negedge clk);
    sendValid = v; sendMask = m; sendType = t; swapReq = sw;
    #1;
    for (int c = 0; c < NC; c++) begin
      check({tag, " swapData"}, swapData[c*PW +: PW], sw[c] ? model[c] : '0);
      check({tag, " irq"}, {4'b0, irq[c]}, {4'b0, model[c] != '0});
    end
    for (int c = 0; c < NC; c++)
      model[c] = (sw[c] ? '0 : model[c]) | expSet(v, m, t, c);
  endtask

  task automatic idle(input string tag);
    step(tag, '0, '0, '0, '0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int c = 0; c < NC; c++) model[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    idle("R9 reset");
    // R1 each code on its own core, then drain
    step("R1 resched", 2'b01, {4'b0, 4'b0001}, {3'd0, 3'd1}, '0);
    step("R1 callset", 2'b01, {4'b0, 4'b0010}, {3'd0, 3'd2}, '0);
    step("R1 callone", 2'b01, {4'b0, 4'b0100}, {3'd0, 3'd3}, '0);
    step("R1 stop",    2'b01, {4'b0, 4'b1000}, {3'd0, 3'd4}, '0);
    step("R1 R5 drain", '0, '0, '0, 4'b1111);
    idle("R5 after drain");
    // R2 stop to all but core 2
    step("R2 multi", 2'b10, {4'b1011, 4'b0}, {3'd4, 3'd0}, '0);
    idle("R2 excluded core");
    // R3 two senders at core 0 and R4 accumulation
    step("R3 or", 2'b11, {4'b0001, 4'b0001}, {3'd2, 3'd3}, '0);
    step("R4 accumulate", 2'b01, {4'b0, 4'b0001}, {3'd0, 3'd1}, '0);
    // R6 set and swap in the same cycle on core 0
    step("R6 same cycle", 2'b01, {4'b0, 4'b0001}, {3'd0, 3'd2}, 4'b1111);
    step("R6 survivor", '0, '0, '0, 4'b0001);
    idle("R6 empty");
    // R8 no-op and unused codes
    step("R8 nop", 2'b11, {4'b1111, 4'b1111}, {3'd0, 3'd5}, '0);
    step("R8 codes", 2'b11, {4'b1111, 4'b1111}, {3'd6, 3'd7}, '0);
    idle("R8 irq low");
    // R10 invalid sender
    step("R10 invalid", 2'b00, {4'b1111, 4'b1111}, {3'd1, 3'd4}, '0);
    idle("R10 irq low");
    // random mix for R2 R3 R4 R5 R7
    for (int i = 0; i < 3000; i++) begin
      logic [NS-1:0] v;
      logic [NS*NC-1:0] m;
      logic [NS*3-1:0] t;
      logic [NC-1:0] sw;
      v  = NS'($urandom);
      m  = (NS*NC)'($urandom);
      t  = (NS*3)'($urandom);
      sw = NC'($urandom) & NC'($urandom);
      step("R2 R3 R4 R5 R7 random", v, m, t, sw);
    end
    step("R5 final drain", '0, '0, '0, '1);
    idle("R7 final");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule